// File: doc/BRIEF.md
# Processor Status Flag Unit

This block keeps the six status flags of a small 8-bit accumulator processor: carry (C), zero (Z), interrupt-disable (I), decimal (D), overflow (V) and negative (N). Each clock cycle the decoder hands it at most one flag operation code together with an 8-bit data value and the accumulator contents. From these the block computes the next flags and registers them. The operations are explicit set or clear commands, the side effects of a register load, the bit-test operation and a full status restore from a byte pulled off the stack.

An active-low external pin can also set overflow. The pin passes through a two-flop synchroniser and then a two-state edge machine. The machine sits in `SO_HIGH` while the synchronised level is high. It takes the *fall* transition to `SO_LOW` when the level drops, and only that transition raises the one-cycle set-overflow pulse. It takes the *rise* transition back to `SO_HIGH` when the level returns high. Software can clear V and then spin on a branch-if-overflow-clear loop, so it reacts to hardware within a few cycles.

A combinational branch evaluator compares the registered flags with a 3-bit condition select and drives a branch-taken output.

Top module: `psr_status_unit`

## Requirements
- R1: After reset the status byte reads 0x24: I=1, the constant bit 5 reads 1, and C, Z, D, V, N and bit 4 read 0. The byte is N at bit 7, V at 6, constant 1 at 5, 0 at 4, D at 3, I at 2, Z at 1 and C at 0.
- R2: Op code 1 sets C and op code 2 clears C. Both take effect after the next rising edge, and all other flags keep their values.
- R3: Op code 3 sets D and op code 4 clears D, leaving all other flags unchanged.
- R4: Op code 5 clears V and leaves all other flags unchanged. No op code sets V on its own: V becomes 1 only through bit-test, pull or the pin.
- R5: Op code 6 (register load) sets N to bit 7 of the data value and sets Z to 1 exactly when the data value is zero. C, I, D and V are unchanged.
- R6: Op code 7 (bit test) sets Z to 1 exactly when the accumulator ANDed with the data value is zero, copies data bit 7 into N and data bit 6 into V, and keeps C, I and D.
- R7: Op code 8 (pull status) loads N, V, D, I, Z and C from data bits 7, 6, 3, 2, 1 and 0. Data bits 5 and 4 are ignored, so the status byte still reads 1 at bit 5 and 0 at bit 4.
- R8: A high-to-low change on `so_pin_n` sets V after the third rising edge that follows it. A pin held low has no further effect, and a low-to-high change has none.
- R9: When the pin's set-overflow pulse and any op code that would write V act in the same cycle, V becomes 1.
- R10: `br_taken` is combinational on the registered flags. The selects are: 0 when C=0, 1 when C=1, 2 when N=0, 3 when N=1, 4 when V=0, 5 when V=1, 6 when Z=0, 7 when Z=1.
- R11: Op code 0 and the unused op codes 9 to 15 change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 4 | Flag operation for this cycle |
| op_data | input | 8 | Loaded value, bit-test operand or pulled status byte |
| acc_in | input | 8 | Accumulator value for the bit-test operation |
| so_pin_n | input | 1 | Asynchronous active-low set-overflow pin |
| br_sel | input | 3 | Branch condition select |
| status | output | 8 | Registered status byte |
| br_taken | output | 1 | Selected branch condition holds |

## Verification
The assertions assume that `op_code`, `op_data` and `acc_in` are settled at each rising edge. They also assume that the set-overflow pulse is the only path outside the op codes that can raise V. For that reason, the checks on clear-overflow and on the op-driven V values are stated only for cycles without a pulse. The stimulus changes every input on the falling clock edge. Each pin change is held for at least three cycles, so every edge reaches the edge machine cleanly and the cycle in which V rises is known in advance.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int DATA_W = 8;
    localparam int N_POS  = DATA_W - 1;
    localparam int V_POS  = DATA_W - 2;
    localparam int K_POS  = 5;
    localparam int B_POS  = 4;
    localparam int D_POS  = 3;
    localparam int I_POS  = 2;
    localparam int Z_POS  = 1;
    localparam int C_POS  = 0;

    localparam int OP_W   = 4;
    localparam int SEL_W  = 3;

    typedef enum logic [OP_W-1:0] {
        FOP_NOP      = 4'd0,
        FOP_SET_C    = 4'd1,
        FOP_CLR_C    = 4'd2,
        FOP_SET_D    = 4'd3,
        FOP_CLR_D    = 4'd4,
        FOP_CLR_V    = 4'd5,
        FOP_LOAD_NZ  = 4'd6,
        FOP_BIT_TEST = 4'd7,
        FOP_PULL     = 4'd8
    } flag_op_e;

    typedef enum logic [SEL_W-1:0] {
        BR_C_CLR = 3'd0,
        BR_C_SET = 3'd1,
        BR_N_CLR = 3'd2,
        BR_N_SET = 3'd3,
        BR_V_CLR = 3'd4,
        BR_V_SET = 3'd5,
        BR_Z_CLR = 3'd6,
        BR_Z_SET = 3'd7
    } br_cond_e;

    typedef enum logic {
        SO_HIGH = 1'b0,
        SO_LOW  = 1'b1
    } so_state_e;

    typedef struct packed {
        logic n;
        logic v;
        logic d;
        logic i;
        logic z;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{n: 1'b0, v: 1'b0, d: 1'b0,
                                       i: 1'b1, z: 1'b0, c: 1'b0};

endpackage

// File: rtl/psr_so_edge.sv
module psr_so_edge
    import psr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic so_fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    so_state_e              state_q;
    so_state_e              state_d;

    // synchroniser chain, idles high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
        end
    end

    assign lvl = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SO_HIGH;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and output
    always_comb begin
        state_d = state_q;
        so_fall = 1'b0;
        unique case (state_q)
            SO_HIGH: begin
                if (!lvl) begin
                    state_d = SO_LOW;
                    so_fall = 1'b1;
                end
            end
            SO_LOW: begin
                if (lvl) begin
                    state_d = SO_HIGH;
                end
            end
            default: begin
                state_d = SO_HIGH;
            end
        endcase
    end

    p_fall_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        so_fall |=> !so_fall);

    p_fall_needs_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        so_fall |-> !sync_q[SYNC_STAGES-1]);

endmodule

// File: rtl/psr_next_flags.sv
module psr_next_flags
    import psr_pkg::*;
(
    input  flags_t             cur,
    input  flag_op_e           op,
    input  logic [DATA_W-1:0]  data,
    input  logic [DATA_W-1:0]  acc,
    input  logic               so_fall,
    output flags_t             nxt
);

    flags_t from_op;

    always_comb begin
        from_op = cur;
        case (op)
            FOP_SET_C:    from_op.c = 1'b1;
            FOP_CLR_C:    from_op.c = 1'b0;
            FOP_SET_D:    from_op.d = 1'b1;
            FOP_CLR_D:    from_op.d = 1'b0;
            FOP_CLR_V:    from_op.v = 1'b0;
            FOP_LOAD_NZ: begin
                from_op.n = data[N_POS];
                from_op.z = (data == '0);
            end
            FOP_BIT_TEST: begin
                from_op.n = data[N_POS];
                from_op.v = data[V_POS];
                from_op.z = ((acc & data) == '0);
            end
            FOP_PULL: begin
                from_op.n = data[N_POS];
                from_op.v = data[V_POS];
                from_op.d = data[D_POS];
                from_op.i = data[I_POS];
                from_op.z = data[Z_POS];
                from_op.c = data[C_POS];
            end
            default: from_op = cur;
        endcase
    end

    always_comb begin
        nxt = from_op;
        if (so_fall) begin
            nxt.v = 1'b1;
        end
    end

endmodule

// File: rtl/psr_branch_eval.sv
module psr_branch_eval
    import psr_pkg::*;
(
    input  flags_t          f,
    input  logic [SEL_W-1:0] sel,
    output logic            taken
);

    br_cond_e cond;
    assign cond = br_cond_e'(sel);

    always_comb begin
        unique case (cond)
            BR_C_CLR: taken = !f.c;
            BR_C_SET: taken =  f.c;
            BR_N_CLR: taken = !f.n;
            BR_N_SET: taken =  f.n;
            BR_V_CLR: taken = !f.v;
            BR_V_SET: taken =  f.v;
            BR_Z_CLR: taken = !f.z;
            BR_Z_SET: taken =  f.z;
            default:  taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/psr_status_unit.sv
module psr_status_unit
    import psr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [OP_W-1:0]       op_code,
    input  logic [DATA_W-1:0]     op_data,
    input  logic [DATA_W-1:0]     acc_in,
    input  logic                  so_pin_n,
    input  logic [SEL_W-1:0]      br_sel,
    output logic [DATA_W-1:0]     status,
    output logic                  br_taken
);

    flags_t   flags_q;
    flags_t   flags_d;
    flag_op_e op;
    logic     so_fall;

    assign op = flag_op_e'(op_code);

    psr_so_edge #(.SYNC_STAGES(2)) u_so_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (so_pin_n),
        .so_fall (so_fall)
    );

    psr_next_flags u_next (
        .cur     (flags_q),
        .op      (op),
        .data    (op_data),
        .acc     (acc_in),
        .so_fall (so_fall),
        .nxt     (flags_d)
    );

    psr_branch_eval u_branch (
        .f     (flags_q),
        .sel   (br_sel),
        .taken (br_taken)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= FLAGS_RESET;
        end else begin
            flags_q <= flags_d;
        end
    end

    always_comb begin
        status        = '0;
        status[N_POS] = flags_q.n;
        status[V_POS] = flags_q.v;
        status[K_POS] = 1'b1;
        status[B_POS] = 1'b0;
        status[D_POS] = flags_q.d;
        status[I_POS] = flags_q.i;
        status[Z_POS] = flags_q.z;
        status[C_POS] = flags_q.c;
    end

    p_set_c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd1) |=> status[C_POS]);

    p_clr_c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd2) |=> !status[C_POS]);

    p_set_d_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd3) |=> status[D_POS]);

    p_clr_v_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd5 && !so_fall) |=> !status[V_POS]);

    p_load_nz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd6) |=>
            (status[N_POS] == $past(op_data[N_POS])) &&
            (status[Z_POS] == ($past(op_data) == '0)) &&
            $stable(status[D_POS]) && $stable(status[C_POS]));

    p_bit_test_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd7 && !so_fall) |=>
            (status[V_POS] == $past(op_data[V_POS])) &&
            (status[Z_POS] == (($past(acc_in) & $past(op_data)) == '0)));

    p_i_only_pull_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code != 4'd8) |=> $stable(status[I_POS]));

    p_pin_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        so_fall |=> status[V_POS]);

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd0 && !so_fall) |=> $stable(status));

    always_comb begin
        if (rst_n) begin
            p_fixed_bits_r1: assert (status[K_POS] && !status[B_POS]);
        end
    end

endmodule

// File: tb/tb_psr_status_unit.sv
module tb_psr_status_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] op_code;
    logic [7:0] op_data;
    logic [7:0] acc_in;
    logic       so_pin_n;
    logic [2:0] br_sel;
    logic [7:0] status;
    logic       br_taken;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] model;

    always #5 clk = ~clk;

    psr_status_unit dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_code  (op_code),
        .op_data  (op_data),
        .acc_in   (acc_in),
        .so_pin_n (so_pin_n),
        .br_sel   (br_sel),
        .status   (status),
        .br_taken (br_taken)
    );

    // model from the requirements; byte layout N7 V6 1 0 D3 I2 Z1 C0
    function automatic logic [7:0] next_model(logic [7:0] s, logic [3:0] op,
                                              logic [7:0] d, logic [7:0] a);
        logic [7:0] r;
        r = s;
        case (op)
            4'd1: r[0] = 1'b1;
            4'd2: r[0] = 1'b0;
            4'd3: r[3] = 1'b1;
            4'd4: r[3] = 1'b0;
            4'd5: r[6] = 1'b0;
            4'd6: begin r[7] = d[7]; r[1] = (d == 8'h00); end
            4'd7: begin r[7] = d[7]; r[6] = d[6]; r[1] = ((a & d) == 8'h00); end
            4'd8: r = {d[7:6], 2'b10, d[3:0]};
            default: r = s;
        endcase
        return r;
    endfunction

    // driver: apply one op on the falling edge, queue the expected byte
    task automatic drive(input logic [3:0] op, input logic [7:0] d,
                         input logic [7:0] a, input bit force_v, input string tag);
        @(negedge clk);
        op_code = op;
        op_data = d;
        acc_in  = a;
        model   = next_model(model, op, d, a);
        if (force_v) model[6] = 1'b1;
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    // monitor: compare just after each rising edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (status !== e) begin
                errors++;
                $display("FAIL %s status actual %02h expected %02h", t, status, e);
            end
        end
    end

    task automatic check_branches(input string tag);
        @(negedge clk);
        op_code = 4'd0;
        for (int k = 0; k < 8; k++) begin
            logic want;
            br_sel = 3'(k);
            #1;
            case (k)
                0: want = !model[0];
                1: want =  model[0];
                2: want = !model[7];
                3: want =  model[7];
                4: want = !model[6];
                5: want =  model[6];
                6: want = !model[1];
                default: want = model[1];
            endcase
            checks++;
            if (br_taken !== want) begin
                errors++;
                $display("FAIL %s sel %0d br_taken actual %b expected %b",
                         tag, k, br_taken, want);
            end
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        op_code  = 4'd0;
        op_data  = 8'h00;
        acc_in   = 8'h00;
        so_pin_n = 1'b1;
        br_sel   = 3'd0;
        model    = 8'h24;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (status !== 8'h24) begin
            errors++;
            $display("FAIL R1 reset status actual %02h expected 24", status);
        end
        check_branches("R10 after reset");

        drive(4'd1, 8'h00, 8'h00, 0, "R2 set C");
        drive(4'd2, 8'hFF, 8'hFF, 0, "R2 clear C");
        drive(4'd1, 8'h00, 8'h00, 0, "R2 set C again");
        drive(4'd3, 8'h00, 8'h00, 0, "R3 set D");
        drive(4'd4, 8'h00, 8'h00, 0, "R3 clear D");
        drive(4'd3, 8'h00, 8'h00, 0, "R3 set D again");
        drive(4'd6, 8'h80, 8'h00, 0, "R5 load negative");
        drive(4'd6, 8'h00, 8'h00, 0, "R5 load zero");
        drive(4'd6, 8'h01, 8'h00, 0, "R5 load positive");
        drive(4'd7, 8'hC0, 8'h3F, 0, "R6 bit test zero with N V");
        check_branches("R10 after bit test");
        drive(4'd7, 8'h41, 8'h01, 0, "R6 bit test nonzero V only");
        drive(4'd5, 8'hFF, 8'hFF, 0, "R4 clear V");
        drive(4'd0, 8'hFF, 8'hFF, 0, "R11 nop");
        for (int u = 9; u < 16; u++) drive(4'(u), 8'hFF, 8'hFF, 0, "R11 unused op");
        drive(4'd8, 8'hFF, 8'h00, 0, "R7 pull all ones");
        check_branches("R10 after pull ones");
        drive(4'd8, 8'h30, 8'h00, 0, "R7 pull only bits 5 4");
        drive(4'd8, 8'h43, 8'h00, 0, "R7 pull mixed");
        drive(4'd5, 8'h00, 8'h00, 0, "R4 clear V before pin");

        // R8: falling pin edge sets V after the third rising edge
        @(negedge clk);
        so_pin_n = 1'b0;
        exp_q.push_back(model); tag_q.push_back("R8 pin sync cycle 1");
        drive(4'd0, 8'h00, 8'h00, 0, "R8 pin sync cycle 2");
        drive(4'd0, 8'h00, 8'h00, 1, "R8 pin sets V");
        drive(4'd5, 8'h00, 8'h00, 0, "R8 held low no effect");
        drive(4'd0, 8'h00, 8'h00, 0, "R8 held low stays");
        @(negedge clk);
        so_pin_n = 1'b1;
        exp_q.push_back(model); tag_q.push_back("R8 rise no effect 1");
        drive(4'd0, 8'h00, 8'h00, 0, "R8 rise no effect 2");
        drive(4'd0, 8'h00, 8'h00, 0, "R8 rise no effect 3");
        drive(4'd0, 8'h00, 8'h00, 0, "R8 rise no effect 4");

        // R9: pin pulse coincides with clear V
        @(negedge clk);
        so_pin_n = 1'b0;
        exp_q.push_back(model); tag_q.push_back("R9 sync 1");
        drive(4'd0, 8'h00, 8'h00, 0, "R9 sync 2");
        drive(4'd5, 8'h00, 8'h00, 1, "R9 pin beats clear V");
        drive(4'd7, 8'h00, 8'hFF, 0, "R6 bit test clears V with pin low");
        @(negedge clk);
        so_pin_n = 1'b1;
        exp_q.push_back(model); tag_q.push_back("R9 release 1");
        drive(4'd0, 8'h00, 8'h00, 0, "R9 release 2");
        drive(4'd0, 8'h00, 8'h00, 0, "R9 release 3");
        @(negedge clk);
        so_pin_n = 1'b0;
        exp_q.push_back(model); tag_q.push_back("R9 second sync 1");
        drive(4'd0, 8'h00, 8'h00, 0, "R9 second sync 2");
        drive(4'd8, 8'h00, 8'h00, 1, "R9 pin beats pull");
        check_branches("R10 after pin");

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule